// File: doc/BRIEF.md
# Remote DMA command engine

This block moves bytes between a host data port and a local packet buffer memory. Before a command, the host loads a start address and a byte count. A three-bit command then starts a transfer in one of two directions. A buffer-to-host transfer fetches bytes from the buffer and offers them one at a time on a valid/ready read port. A host-to-buffer transfer accepts bytes on a valid/ready write port and stores each one in the buffer. Each byte moves the address up by one and the count down by one. A sticky done flag reports when the count has reached zero.

Setting the top command bit aborts the active transfer. The address and count keep the values they had advanced to; they are not put back. If an abort leaves bytes outstanding, the data port stays open for exactly one more access, which returns the channel to a clean state. Two rules protect the active transfer. A command for the opposite direction is ignored while a transfer runs. A command issued with a zero count finishes at once and touches no memory.

Top module: `rdma_engine`

## Requirements
- R1: The command field `cmd_val[2:0]` is taken when `cmd_wr` is high. Code 001 and code 011 each start a buffer-to-host read, and code 010 starts a host-to-buffer write. Code 000 has no effect.
- R2: Each transferred byte advances `cur_addr` by one and lowers `cur_cnt` by one. Bytes move in ascending address order. A buffer read returns `mem_rdata` RD_LAT cycles after `mem_rd`.
- R3: In a read, each byte is offered on `hrd_data` with `hrd_valid` high and is held until `hrd_ready` is high. When the last byte is taken, `busy` falls and `done_flag` is set at the same clock edge.
- R4: In a write, `hwr_ready` is high while a byte is awaited. A byte accepted with `hwr_valid` is written with `mem_wr` to the current address in the next cycle. The write of the last byte ends the transfer and sets `done_flag`.
- R5: A read or write command issued while `cur_cnt` is zero sets `done_flag` at the next edge. The block stays idle and raises no memory strobe.
- R6: Any command with bit 2 set makes the block idle at the next edge and sets `done_flag`. This holds whether a transfer is active or not.
- R7: An abort leaves `cur_addr` and `cur_cnt` at their advanced values.
- R8: A read or write command issued while a transfer is active is ignored. The active transfer continues in its own direction.
- R9: After an abort that leaves `cur_cnt` nonzero, `hrd_valid` and `hwr_ready` stay high until one handshake on either port. That handshake causes no memory access and no change to the address or the count. Until it happens, read and write commands are ignored.
- R10: `done_clr` high clears `done_flag`. A set event in the same cycle takes priority over the clear.
- R11: `addr_ld` and `cnt_ld` load the address and the count only while the block is idle. While a transfer is active they are ignored.
- R12: After reset the block is idle, `done_flag` is low, and no strobe or handshake output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command strobe |
| cmd_val | input | 3 | Command code |
| addr_ld | input | 1 | Load start address |
| addr_in | input | AW | Start address value |
| cnt_ld | input | 1 | Load byte count |
| cnt_in | input | CW | Byte count value |
| done_clr | input | 1 | Clear done flag |
| hrd_valid | output | 1 | Read port holds a byte |
| hrd_data | output | DW | Read port byte |
| hrd_ready | input | 1 | Host takes the read byte |
| hwr_valid | input | 1 | Host offers a write byte |
| hwr_data | input | DW | Write port byte |
| hwr_ready | output | 1 | Write port accepts a byte |
| mem_addr | output | AW | Buffer address |
| mem_rd | output | 1 | Buffer read strobe |
| mem_wr | output | 1 | Buffer write strobe |
| mem_wdata | output | DW | Buffer write data |
| mem_rdata | input | DW | Buffer read data |
| busy | output | 1 | Transfer active |
| done_flag | output | 1 | Sticky completion flag |
| cur_addr | output | AW | Current address |
| cur_cnt | output | CW | Remaining byte count |

## Verification
The bench sweeps several start addresses, including one whose low byte wraps, across counts of zero to four. It writes each region and then reads it back using both read codes. A design that decremented past zero, or that started a transfer on a zero count, would show extra strobes or a wrong final address. The bench aborts both a read and a write in mid-transfer and checks that the advanced address is kept, not restored. It then checks that exactly one port access is needed and has no side effect; a design that skipped this access or let a new command in early would be caught. The bench also issues a command for the opposite direction and a load while busy. A design that switched direction or took the load would corrupt the address sequence.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_FETCH = 3'd1,
      ST_RD_WAIT  = 3'd2,
      ST_RD_HOLD  = 3'd3,
      ST_WR_IDLE  = 3'd4,
      ST_WR_PUT   = 3'd5
   } rdma_state_e;

   localparam logic [1:0] DIR_TO_BUF = 2'b10;
endpackage

// File: rtl/rdma_ctr.sv
module rdma_ctr #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          ld_ok,
   input  logic          addr_ld,
   input  logic [AW-1:0] addr_in,
   input  logic          cnt_ld,
   input  logic [CW-1:0] cnt_in,
   output logic [AW-1:0] addr_q,
   output logic [CW-1:0] cnt_q,
   output logic          cnt_zero,
   output logic          cnt_one
);
   localparam logic [AW-1:0] A_ONE = AW'(1);
   localparam logic [CW-1:0] C_ONE = CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (step) begin
         addr_q <= addr_q + A_ONE;
         cnt_q  <= cnt_q - C_ONE;
      end else if (ld_ok) begin
         if (addr_ld) addr_q <= addr_in;
         if (cnt_ld)  cnt_q  <= cnt_in;
      end
   end

   assign cnt_zero = (cnt_q == '0);
   assign cnt_one  = (cnt_q == C_ONE);

   AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (addr_q == $past(addr_q) + A_ONE) && (cnt_q == $past(cnt_q) - C_ONE)); // R2
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !cnt_zero); // R2
   AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_ok && !step) |=> ($stable(addr_q) && $stable(cnt_q))); // R11
endmodule

// File: rtl/rdma_rdlat.sv
module rdma_rdlat #(
   parameter int LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic ret_o
);
   generate
      if (LAT == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= req_i;
         end
         assign ret_o = q;
      end else begin : g_chain
         logic [LAT-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[LAT-2:0], req_i};
         end
         assign ret_o = sr[LAT-1];
      end
   endgenerate
endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
   import rdma_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wr,
   input  logic [2:0]    cmd_val,
   input  logic          cnt_zero,
   input  logic          cnt_one,
   input  logic          rd_ret,
   input  logic [DW-1:0] mem_rdata,
   input  logic          hrd_ready,
   input  logic          hwr_valid,
   input  logic [DW-1:0] hwr_data,
   input  logic          done_clr,
   output logic          step,
   output logic          ld_ok,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] port_q,
   output logic          hrd_valid,
   output logic          hwr_ready,
   output logic          busy,
   output logic          done_flag
);
   rdma_state_e st, st_n;
   logic stale, stale_n, done_set;
   logic abort, go, go_wr, is_rd, is_wr, stale_hit;

   assign abort     = cmd_wr & cmd_val[2];
   assign go        = cmd_wr & ~cmd_val[2] & (cmd_val[1:0] != 2'b00);
   assign go_wr     = go & (cmd_val[1:0] == DIR_TO_BUF);
   assign is_rd     = (st == ST_RD_FETCH) || (st == ST_RD_WAIT) || (st == ST_RD_HOLD);
   assign is_wr     = (st == ST_WR_IDLE) || (st == ST_WR_PUT);
   assign step      = ((st == ST_RD_WAIT) && rd_ret) || (st == ST_WR_PUT);
   assign stale_hit = (st == ST_IDLE) && stale && (hrd_ready || hwr_valid);
   assign mem_rd    = (st == ST_RD_FETCH);
   assign mem_wr    = (st == ST_WR_PUT);
   assign hrd_valid = (st == ST_RD_HOLD) || ((st == ST_IDLE) && stale);
   assign hwr_ready = (st == ST_WR_IDLE) || ((st == ST_IDLE) && stale);
   assign busy      = (st != ST_IDLE);
   assign ld_ok     = (st == ST_IDLE);

   always_comb begin
      st_n     = st;
      stale_n  = stale;
      done_set = 1'b0;
      if (abort) begin
         st_n     = ST_IDLE;
         done_set = 1'b1;
         if (st != ST_IDLE) stale_n = step ? !cnt_one : !cnt_zero;
      end else begin
         case (st)
            ST_IDLE: begin
               if (stale_hit) stale_n = 1'b0;
               else if (go && !stale) begin
                  if (cnt_zero) done_set = 1'b1;
                  else          st_n = go_wr ? ST_WR_IDLE : ST_RD_FETCH;
               end
            end
            ST_RD_FETCH: st_n = ST_RD_WAIT;
            ST_RD_WAIT:  if (rd_ret) st_n = ST_RD_HOLD;
            ST_RD_HOLD: begin
               if (hrd_ready) begin
                  if (cnt_zero) begin
                     st_n     = ST_IDLE;
                     done_set = 1'b1;
                  end else begin
                     st_n = ST_RD_FETCH;
                  end
               end
            end
            ST_WR_IDLE: if (hwr_valid) st_n = ST_WR_PUT;
            ST_WR_PUT: begin
               if (cnt_one) begin
                  st_n     = ST_IDLE;
                  done_set = 1'b1;
               end else begin
                  st_n = ST_WR_IDLE;
               end
            end
            default: st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         stale     <= 1'b0;
         done_flag <= 1'b0;
         port_q    <= '0;
      end else begin
         st    <= st_n;
         stale <= stale_n;
         if (done_set)      done_flag <= 1'b1;
         else if (done_clr) done_flag <= 1'b0;
         if ((st == ST_RD_WAIT) && rd_ret)                   port_q <= mem_rdata;
         else if ((st == ST_WR_IDLE) && hwr_valid && !abort) port_q <= hwr_data;
      end
   end

   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> ((st == ST_IDLE) && done_flag)); // R6
   AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IDLE) && !stale && go && cnt_zero) |=> ((st == ST_IDLE) && done_flag)); // R5
   AST_DIR_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && go) |=> !is_rd); // R8
   AST_DIR_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && go) |=> !is_wr); // R8
   AST_STALE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IDLE) && stale && go) |=> (st == ST_IDLE)); // R9
   AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_clr && !cmd_wr && (st == ST_IDLE)) |=> !done_flag); // R10
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine #(
   parameter int AW     = 16,
   parameter int CW     = 16,
   parameter int DW     = 8,
   parameter int RD_LAT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wr,
   input  logic [2:0]    cmd_val,
   input  logic          addr_ld,
   input  logic [AW-1:0] addr_in,
   input  logic          cnt_ld,
   input  logic [CW-1:0] cnt_in,
   input  logic          done_clr,
   output logic          hrd_valid,
   output logic [DW-1:0] hrd_data,
   input  logic          hrd_ready,
   input  logic          hwr_valid,
   input  logic [DW-1:0] hwr_data,
   output logic          hwr_ready,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done_flag,
   output logic [AW-1:0] cur_addr,
   output logic [CW-1:0] cur_cnt
);
   initial begin : p_param_chk
      assert (RD_LAT >= 1 && RD_LAT <= 4) else $error("RD_LAT must be 1..4");
      assert (AW >= 2 && CW >= 2)         else $error("AW and CW must be at least 2");
      assert (DW >= 1)                    else $error("DW must be positive");
   end

   logic step, ld_ok, cnt_zero, cnt_one, rd_ret;
   logic [DW-1:0] port_q;

   rdma_ctr #(.AW(AW), .CW(CW)) ctr_i (
      .clk(clk), .rst_n(rst_n), .step(step), .ld_ok(ld_ok),
      .addr_ld(addr_ld), .addr_in(addr_in), .cnt_ld(cnt_ld), .cnt_in(cnt_in),
      .addr_q(cur_addr), .cnt_q(cur_cnt), .cnt_zero(cnt_zero), .cnt_one(cnt_one)
   );

   rdma_rdlat #(.LAT(RD_LAT)) lat_i (
      .clk(clk), .rst_n(rst_n), .req_i(mem_rd), .ret_o(rd_ret)
   );

   rdma_seq #(.DW(DW)) seq_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
      .cnt_zero(cnt_zero), .cnt_one(cnt_one), .rd_ret(rd_ret),
      .mem_rdata(mem_rdata), .hrd_ready(hrd_ready), .hwr_valid(hwr_valid),
      .hwr_data(hwr_data), .done_clr(done_clr), .step(step), .ld_ok(ld_ok),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .port_q(port_q),
      .hrd_valid(hrd_valid), .hwr_ready(hwr_ready), .busy(busy),
      .done_flag(done_flag)
   );

   assign mem_addr  = cur_addr;
   assign mem_wdata = port_q;
   assign hrd_data  = port_q;

   AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_val[2] && busy && !step) |=> ($stable(cur_addr) && $stable(cur_cnt))); // R7
endmodule

// File: tb/rdma_engine_tb.sv
module rdma_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [2:0]  cmd_val = 3'b000;
   logic        addr_ld = 1'b0, cnt_ld = 1'b0, done_clr = 1'b0;
   logic [15:0] addr_in = '0, cnt_in = '0;
   logic        hrd_valid, hrd_ready = 1'b0;
   logic [7:0]  hrd_data;
   logic        hwr_valid = 1'b0, hwr_ready;
   logic [7:0]  hwr_data = '0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        busy, done_flag;
   logic [15:0] cur_addr, cur_cnt;

   int errors = 0, checks = 0, cyc = 0, nstrobe = 0;
   logic [7:0] mem [256];
   logic [7:0] expm [256];

   always #10 clk = ~clk;

   rdma_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
      .addr_ld(addr_ld), .addr_in(addr_in), .cnt_ld(cnt_ld), .cnt_in(cnt_in),
      .done_clr(done_clr), .hrd_valid(hrd_valid), .hrd_data(hrd_data),
      .hrd_ready(hrd_ready), .hwr_valid(hwr_valid), .hwr_data(hwr_data),
      .hwr_ready(hwr_ready), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done_flag(done_flag), .cur_addr(cur_addr), .cur_cnt(cur_cnt)
   );

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_rd || mem_wr) nstrobe <= nstrobe + 1;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int expv);
      checks = checks + 1;
      if (act != expv) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic load(input int a, input int n);
      addr_ld = 1'b1; addr_in = 16'(a); cnt_ld = 1'b1; cnt_in = 16'(n);
      tick();
      addr_ld = 1'b0; cnt_ld = 1'b0;
   endtask

   task automatic issue(input logic [2:0] c);
      cmd_wr = 1'b1; cmd_val = c;
      tick();
      cmd_wr = 1'b0; cmd_val = 3'b000;
   endtask

   task automatic clear_done();
      done_clr = 1'b1;
      tick();
      done_clr = 1'b0;
      chk("R10", "done cleared", int'(done_flag), 0);
   endtask

   task automatic wait_sig(input bit rd, output bit ok);
      ok = 1'b0;
      for (int k = 0; k < 20; k++) begin
         if ((rd && hrd_valid) || (!rd && hwr_ready)) begin
            ok = 1'b1;
            break;
         end
         tick();
      end
   endtask

   task automatic do_write(input int a, input int n);
      bit ok;
      int s0;
      clear_done();
      load(a, n);
      s0 = nstrobe;
      issue(3'b010);
      if (n == 0) begin
         chk("R5", "zero-count write done", int'(done_flag), 1);
         chk("R5", "zero-count write idle", int'(busy), 0);
         chk("R5", "zero-count write no strobe", nstrobe, s0);
         return;
      end
      for (int i = 0; i < n; i++) begin
         logic [7:0] v;
         v = 8'(i * 13 + a + 5);
         wait_sig(1'b0, ok);
         chk("R4", "write ready", int'(ok), 1);
         hwr_valid = 1'b1; hwr_data = v;
         tick();
         hwr_valid = 1'b0;
         expm[8'(a + i)] = v;
      end
      tick();
      chk("R4", "write done flag", int'(done_flag), 1);
      chk("R4", "write idle", int'(busy), 0);
      chk("R2", "write final addr", int'(cur_addr), int'(16'(a + n)));
      chk("R2", "write final count", int'(cur_cnt), 0);
      chk("R2", "write strobes", nstrobe - s0, n);
   endtask

   task automatic do_read(input int a, input int n, input logic [2:0] c);
      bit ok;
      int s0;
      clear_done();
      load(a, n);
      s0 = nstrobe;
      issue(c);
      if (n == 0) begin
         chk("R5", "zero-count read done", int'(done_flag), 1);
         chk("R5", "zero-count read idle", int'(busy), 0);
         chk("R5", "zero-count read no strobe", nstrobe, s0);
         return;
      end
      chk("R1", "read started", int'(busy), 1);
      for (int i = 0; i < n; i++) begin
         wait_sig(1'b1, ok);
         chk("R3", "read valid", int'(ok), 1);
         chk("R3", "read byte", int'(hrd_data), int'(expm[8'(a + i)]));
         hrd_ready = 1'b1;
         tick();
         hrd_ready = 1'b0;
      end
      chk("R3", "read done flag", int'(done_flag), 1);
      chk("R3", "read idle", int'(busy), 0);
      chk("R2", "read final addr", int'(cur_addr), int'(16'(a + n)));
      chk("R2", "read final count", int'(cur_cnt), 0);
   endtask

   initial begin
      bit ok;
      int s0;
      int starts [3] = '{16'h0010, 16'h00FD, 16'h1280};
      for (int i = 0; i < 256; i++) begin
         mem[i]  = 8'(i * 7 + 3);
         expm[i] = 8'(i * 7 + 3);
      end
      repeat (3) tick();
      chk("R12", "reset busy", int'(busy), 0);
      chk("R12", "reset done", int'(done_flag), 0);
      chk("R12", "reset read valid", int'(hrd_valid), 0);
      chk("R12", "reset write ready", int'(hwr_ready), 0);
      chk("R12", "reset strobes", int'(mem_rd | mem_wr), 0);
      rst_n = 1'b1;
      tick();

      // R1 code 000 has no effect
      load(16'h0020, 3);
      s0 = nstrobe;
      issue(3'b000);
      chk("R1", "nop stays idle", int'(busy), 0);
      chk("R1", "nop no done", int'(done_flag), 0);
      chk("R1", "nop no strobe", nstrobe, s0);

      // sweep: writes then readback with both read codes
      foreach (starts[si]) begin
         for (int n = 0; n <= 4; n++) begin
            do_write(starts[si], n);
            do_read(starts[si], n, (n % 2 == 0) ? 3'b001 : 3'b011);
         end
      end

      // R6 abort while idle sets done
      clear_done();
      issue(3'b111);
      chk("R6", "idle abort done", int'(done_flag), 1);
      chk("R6", "idle abort idle", int'(busy), 0);

      // R6/R7/R9 read aborted mid-transfer
      clear_done();
      load(16'h0040, 5);
      issue(3'b001);
      for (int i = 0; i < 2; i++) begin
         wait_sig(1'b1, ok);
         hrd_ready = 1'b1;
         tick();
         hrd_ready = 1'b0;
      end
      wait_sig(1'b1, ok);
      issue(3'b100);
      chk("R6", "read abort idle", int'(busy), 0);
      chk("R6", "read abort done", int'(done_flag), 1);
      chk("R7", "read abort addr kept", int'(cur_addr), 16'h0043);
      chk("R7", "read abort count kept", int'(cur_cnt), 2);
      chk("R9", "stale read valid", int'(hrd_valid), 1);
      chk("R9", "stale write ready", int'(hwr_ready), 1);
      s0 = nstrobe;
      issue(3'b001);
      chk("R9", "command ignored while stale", int'(busy), 0);
      hrd_ready = 1'b1;
      tick();
      hrd_ready = 1'b0;
      chk("R9", "stale cleared valid", int'(hrd_valid), 0);
      chk("R9", "stale cleared ready", int'(hwr_ready), 0);
      chk("R9", "stale access no strobe", nstrobe, s0);
      chk("R9", "stale access addr", int'(cur_addr), 16'h0043);

      // R7/R9 write aborted mid-transfer
      clear_done();
      load(16'h0080, 4);
      issue(3'b010);
      wait_sig(1'b0, ok);
      hwr_valid = 1'b1; hwr_data = 8'hA5;
      tick();
      hwr_valid = 1'b0;
      expm[8'h80] = 8'hA5;
      wait_sig(1'b0, ok);
      issue(3'b110);
      chk("R7", "write abort addr kept", int'(cur_addr), 16'h0081);
      chk("R7", "write abort count kept", int'(cur_cnt), 3);
      chk("R6", "write abort done", int'(done_flag), 1);
      s0 = nstrobe;
      hwr_valid = 1'b1; hwr_data = 8'h3C;
      tick();
      hwr_valid = 1'b0;
      chk("R9", "write stale access no strobe", nstrobe, s0);
      chk("R9", "write stale cleared", int'(hwr_ready), 0);
      chk("R9", "write stale count", int'(cur_cnt), 3);

      // R8 opposite command ignored, R11 load ignored while busy
      clear_done();
      load(16'h0090, 3);
      issue(3'b010);
      wait_sig(1'b0, ok);
      issue(3'b001);
      chk("R8", "still busy", int'(busy), 1);
      chk("R8", "still in write", int'(hwr_ready), 1);
      chk("R8", "no read offered", int'(hrd_valid), 0);
      load(16'h5555, 9);
      chk("R11", "busy load addr", int'(cur_addr), 16'h0090);
      for (int i = 0; i < 3; i++) begin
         wait_sig(1'b0, ok);
         hwr_valid = 1'b1; hwr_data = 8'(8'h60 + i);
         tick();
         hwr_valid = 1'b0;
         expm[8'(8'h90 + i)] = 8'(8'h60 + i);
      end
      tick();
      chk("R11", "busy load final addr", int'(cur_addr), 16'h0093);
      chk("R8", "write completed", int'(done_flag), 1);
      do_read(16'h0090, 3, 3'b011);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule